// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the register-side half of a byte-oriented I2C master. A processor reaches it through a simple 32-bit register port with word-aligned addresses. The block holds the controller configuration and the two SCL phase counts. It keeps one sticky flag for each of seven bus-engine events and folds the flags into a single interrupt line. Commands written by software go to the bus engine as single-cycle strobes.

The bus engine sits beside this block and is not part of it. It reports events as one-cycle pulses, raises a busy level while it owns the bus, and delivers each received byte with a valid pulse. Software clears handled events by writing ones to a dedicated clear register. The intended idiom is to read status and write the same value back, which clears exactly the flags it saw and no others.

Top module: `iic_csr_unit`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `cmd_valid` is low and `ctl_enable` is low.
- R2: Register index is `bus_addr[4:2]`: 0 control (bits 8..0 writable and readable), 1 command, 2 event clear, 3 status, 4 SCL high count, 5 SCL low count, 6 transmit byte (bits 7..0), 7 receive byte. The SCL counts and the transmit byte drive `scl_hi_cnt`, `scl_lo_cnt` and `tx_byte`, and read back what was written.
- R3: A pulse on `eng_evt[k]` sets status bit k, and the bit stays set until it is cleared. Event bits are 6 start, 5 end, 4 send, 3 receive, 2 ack error, 1 arbitration lost, 0 transfer over.
- R4: A write to the clear register clears each status bit 6..0 whose data bit is 1 and leaves the others unchanged. Writing back a value read from status clears exactly the pending flags.
- R5: When an event and a clear for the same flag fall in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when control bit 8 (enable), control bit 7 (global unmask) and at least one pending flag whose control bit k (same position as status) is 1 are all set.
- R7: Clearing control bit 7 alone drops `irq` but leaves the flags pending. Setting it again raises `irq` again.
- R8: Status bit 7 follows `eng_busy`. Writes to status have no effect.
- R9: A command write made while `eng_busy` is low gives `cmd_valid` high for exactly the next cycle, with `cmd_bits` equal to `bus_wdata[4:0]`. A command write made while busy is dropped.
- R10: The receive register returns the byte last delivered with `eng_rx_valid` in bits 7..0 and zeros above. The clear and command registers read zero, and writes to the receive register have no effect.
- R11: Writing 0 to control drives `ctl_enable` low and holds `irq` low even while flags are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_evt | input | 7 | Event pulses from the bus engine |
| eng_busy | input | 1 | Bus engine owns the bus |
| eng_rx_valid | input | 1 | Received byte valid |
| eng_rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | Single-cycle command strobe |
| cmd_bits | output | 5 | Command field latched from the write |
| tx_byte | output | 8 | Byte to transmit |
| scl_hi_cnt | output | 16 | SCL high phase count |
| scl_lo_cnt | output | 16 | SCL low phase count |
| ctl_enable | output | 1 | Controller enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: seven event sources, a 16-bit count width and a 32-bit data bus. This makes every flag position and all eight register indices reachable. With these values, random event bursts mixed with random clear writes, control writes and busy levels cover the two-level mask over all source positions. They also hit set-versus-clear collisions on individual bits often. Directed cases cover the write-back-status idiom, the global unmask toggle and commands issued while busy.

// File: rtl/iic_csr_pkg.sv
package iic_csr_pkg;
  localparam int unsigned EVT_N  = 7;
  localparam int unsigned CMD_W  = 5;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_CMD   = 3'd1,
    IDX_CLR   = 3'd2,
    IDX_STAT  = 3'd3,
    IDX_SCLH  = 3'd4,
    IDX_SCLL  = 3'd5,
    IDX_TX    = 3'd6,
    IDX_RX    = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/iic_evt_flags.sv
module iic_evt_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q, d;
    always_comb d = set_i[g] | (q & ~clr_i[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flags_o[g] = q;

    // R3 / R5: an event always leaves the flag set, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);
    // R4: a clear with no event leaves the flag low
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
    // R3: without a clear the flag never drops
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
  end
endmodule

// File: rtl/iic_irq_merge.sv
module iic_irq_merge #(
  parameter int unsigned N = 7
) (
  input  logic         enable_i,
  input  logic         gunmask_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] flags_i,
  output logic         irq_o
);
  logic any_src;
  always_comb begin
    any_src = |(flags_i & mask_i);
    irq_o   = enable_i & gunmask_i & any_src;
  end

  // R6: a raised line always has an unmasked pending source behind it
  always_comb begin
    if (irq_o) p_irq_src_r6: assert (|(flags_i & mask_i));
  end
endmodule

// File: rtl/iic_cmd_issue.sv
module iic_cmd_issue #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit_i,
  input  logic          busy_i,
  input  logic [CW-1:0] bits_i,
  output logic          valid_o,
  output logic [CW-1:0] bits_o
);
  logic          fire;
  logic          valid_d;
  logic [CW-1:0] bits_q;

  always_comb begin
    fire    = wr_hit_i & ~busy_i;
    valid_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bits_q <= '0;
    else if (fire) bits_q <= bits_i;
  end
  assign bits_o = bits_q;

  // R9: a busy engine never receives a strobe in the following cycle
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !valid_o);
  // R9: no strobe appears without a command write
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit_i |=> !valid_o);
endmodule

// File: rtl/iic_csr_unit.sv
module iic_csr_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [6:0]        eng_evt,
  input  logic              eng_busy,
  input  logic              eng_rx_valid,
  input  logic [7:0]        eng_rx_byte,
  output logic              cmd_valid,
  output logic [4:0]        cmd_bits,
  output logic [7:0]        tx_byte,
  output logic [CNT_W-1:0]  scl_hi_cnt,
  output logic [CNT_W-1:0]  scl_lo_cnt,
  output logic              ctl_enable,
  output logic              irq
);
  import iic_csr_pkg::*;

  localparam int unsigned CTRL_W = EVT_N + 2;
  localparam int unsigned EN_BIT = EVT_N + 1;
  localparam int unsigned GU_BIT = EVT_N;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  reg_idx_e idx;
  assign idx = reg_idx_e'(bus_addr[4:2]);

  logic we_ctrl, we_cmd, we_clr, we_sclh, we_scll, we_tx;
  always_comb begin
    we_ctrl = bus_wr && (idx == IDX_CTRL);
    we_cmd  = bus_wr && (idx == IDX_CMD);
    we_clr  = bus_wr && (idx == IDX_CLR);
    we_sclh = bus_wr && (idx == IDX_SCLH);
    we_scll = bus_wr && (idx == IDX_SCLL);
    we_tx   = bus_wr && (idx == IDX_TX);
  end

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  sclh_q, scll_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)        ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)        sclh_q <= '0;
    else if (we_sclh) sclh_q <= bus_wdata[CNT_W-1:0];
  end
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)        scll_q <= '0;
    else if (we_scll) scll_q <= bus_wdata[CNT_W-1:0];
  end
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)      tx_q <= '0;
    else if (we_tx) tx_q <= bus_wdata[BYTE_W-1:0];
  end
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)             rx_q <= '0;
    else if (eng_rx_valid) rx_q <= eng_rx_byte;
  end

  logic [EVT_N-1:0] clr_vec, flags;
  assign clr_vec = we_clr ? bus_wdata[EVT_N-1:0] : '0;

  iic_evt_flags #(.N(EVT_N)) u_flags (
    .clk     (clk),
    .rst_n   (rs_n),
    .set_i   (eng_evt),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  iic_irq_merge #(.N(EVT_N)) u_irq (
    .enable_i  (ctrl_q[EN_BIT]),
    .gunmask_i (ctrl_q[GU_BIT]),
    .mask_i    (ctrl_q[EVT_N-1:0]),
    .flags_i   (flags),
    .irq_o     (irq)
  );

  iic_cmd_issue #(.CW(CMD_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rs_n),
    .wr_hit_i (we_cmd),
    .busy_i   (eng_busy),
    .bits_i   (bus_wdata[CMD_W-1:0]),
    .valid_o  (cmd_valid),
    .bits_o   (cmd_bits)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      IDX_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      IDX_STAT: bus_rdata[EVT_N:0]    = {eng_busy, flags};
      IDX_SCLH: bus_rdata[CNT_W-1:0]  = sclh_q;
      IDX_SCLL: bus_rdata[CNT_W-1:0]  = scll_q;
      IDX_TX:   bus_rdata[BYTE_W-1:0] = tx_q;
      IDX_RX:   bus_rdata[BYTE_W-1:0] = rx_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign tx_byte    = tx_q;
  assign scl_hi_cnt = sclh_q;
  assign scl_lo_cnt = scll_q;
  assign ctl_enable = ctrl_q[EN_BIT];

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  // R10: the receive byte only moves when the engine delivers one
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rs_n)
    !eng_rx_valid |=> $stable(rx_q));
  // R11: a disabled controller keeps the line low
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rs_n)
    !ctl_enable |-> !irq);
endmodule

// File: tb/iic_csr_unit_tb.sv
module iic_csr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [6:0]  eng_evt;
  logic        eng_busy, eng_rx_valid;
  logic [7:0]  eng_rx_byte;
  logic        cmd_valid, ctl_enable, irq;
  logic [4:0]  cmd_bits;
  logic [7:0]  tx_byte;
  logic [15:0] scl_hi_cnt, scl_lo_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  iic_csr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_evt(eng_evt),
    .eng_busy(eng_busy), .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
    .cmd_valid(cmd_valid), .cmd_bits(cmd_bits), .tx_byte(tx_byte),
    .scl_hi_cnt(scl_hi_cnt), .scl_lo_cnt(scl_lo_cnt), .ctl_enable(ctl_enable),
    .irq(irq)
  );

  function automatic bit exp_irq(input logic [8:0] c, input logic [6:0] f);
    return c[8] && c[7] && ((f & c[6:0]) != 7'd0);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [6:0] e);
    eng_evt = e;
    @(negedge clk);
    eng_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [6:0]  fm;
    logic [8:0]  cm;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    eng_evt = 0; eng_busy = 0; eng_rx_valid = 0; eng_rx_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk("R1 reg reset", v, 32'd0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R1 enable", {31'd0, ctl_enable}, 32'd0);

    // R2 map and readback
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); chk("R2 ctrl", v, 32'h1FF);
    chk("R2 enable out", {31'd0, ctl_enable}, 32'd1);
    wr(5'h10, 32'h0001_0123); rd(5'h10, v); chk("R2 sclh", v, 32'h0123);
    chk("R2 sclh out", {16'd0, scl_hi_cnt}, 32'h0123);
    wr(5'h14, 32'h0000_BEEF); rd(5'h14, v); chk("R2 scll", v, 32'hBEEF);
    chk("R2 scll out", {16'd0, scl_lo_cnt}, 32'hBEEF);
    wr(5'h18, 32'h0000_01A5); rd(5'h18, v); chk("R2 tx", v, 32'hA5);
    chk("R2 tx out", {24'd0, tx_byte}, 32'hA5);

    // R3 / R6 sticky flags and irq
    wr(5'h00, 32'h185);
    pulse_evt(7'h40);
    repeat (2) @(negedge clk);
    rd(5'h0C, v); chk("R3 start sticky", v, 32'h40);
    chk("R6 start masked", {31'd0, irq}, 32'd0);
    pulse_evt(7'h04);
    chk("R6 ack unmasked", {31'd0, irq}, 32'd1);

    // R7 global unmask toggle
    wr(5'h00, 32'h105); rd(5'h0C, v);
    chk("R7 irq off", {31'd0, irq}, 32'd0);
    chk("R7 flags kept", v, 32'h44);
    wr(5'h00, 32'h185);
    chk("R7 irq back", {31'd0, irq}, 32'd1);

    // R11 disable
    wr(5'h00, 32'h0);
    chk("R11 irq low", {31'd0, irq}, 32'd0);
    chk("R11 enable low", {31'd0, ctl_enable}, 32'd0);
    wr(5'h00, 32'h185);

    // R4 write-back idiom
    pulse_evt(7'h01);
    rd(5'h0C, v);
    pulse_evt(7'h10);
    wr(5'h08, v);
    rd(5'h0C, v); chk("R4 writeback clears seen only", v, 32'h10);
    wr(5'h08, 32'h7F); rd(5'h0C, v); chk("R4 clear all", v, 32'h0);
    rd(5'h08, v); chk("R10 clear reads zero", v, 32'h0);

    // R5 collision
    pulse_evt(7'h22); rd(5'h0C, v); chk("R5 setup", v, 32'h22);
    bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h22; eng_evt = 7'h02;
    @(negedge clk);
    bus_wr = 1'b0; eng_evt = '0;
    rd(5'h0C, v); chk("R5 set wins", v, 32'h02);
    wr(5'h08, 32'h7F);

    // R8 busy and status write
    eng_busy = 1'b1; rd(5'h0C, v); chk("R8 busy bit", v, 32'h80);
    eng_busy = 1'b0;
    pulse_evt(7'h08);
    wr(5'h0C, 32'h0); rd(5'h0C, v); chk("R8 status write ignored", v, 32'h08);
    wr(5'h08, 32'h7F);

    // R9 commands
    wr(5'h04, 32'hFFFF_FFFE);
    chk("R9 strobe", {31'd0, cmd_valid}, 32'd1);
    chk("R9 bits", {27'd0, cmd_bits}, 32'h1E);
    @(negedge clk);
    chk("R9 single cycle", {31'd0, cmd_valid}, 32'd0);
    eng_busy = 1'b1;
    wr(5'h04, 32'h09);
    chk("R9 busy dropped", {31'd0, cmd_valid}, 32'd0);
    chk("R9 bits held", {27'd0, cmd_bits}, 32'h1E);
    eng_busy = 1'b0;
    rd(5'h04, v); chk("R10 cmd reads zero", v, 32'h0);

    // R10 receive
    eng_rx_valid = 1'b1; eng_rx_byte = 8'hC3;
    @(negedge clk);
    eng_rx_valid = 1'b0; eng_rx_byte = 8'h00;
    rd(5'h1C, v); chk("R10 rx byte", v, 32'hC3);
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, v); chk("R10 rx write ignored", v, 32'hC3);

    // random mix for R3 R4 R5 R6 R8
    wr(5'h08, 32'h7F);
    fm = '0; cm = 9'h185; wr(5'h00, {23'd0, cm});
    for (int i = 0; i < 400; i++) begin
      logic [6:0] e;
      logic [31:0] d;
      int sel;
      logic b;
      e   = (($urandom % 3) == 0) ? 7'($urandom) : 7'd0;
      d   = $urandom;
      sel = $urandom % 10;
      b   = 1'($urandom);
      eng_evt = e; eng_busy = b;
      if (sel < 5) begin
        bus_wr = 1; bus_addr = 5'h08; bus_wdata = d;
        fm = e | (fm & ~d[6:0]);
      end else if (sel == 5) begin
        bus_wr = 1; bus_addr = 5'h00; bus_wdata = d;
        cm = d[8:0]; fm = e | fm;
      end else begin
        fm = e | fm;
      end
      @(negedge clk);
      bus_wr = 0; eng_evt = '0;
      rd(5'h0C, v); chk("R3 R4 R5 R8 random status", v, {24'd0, b, fm});
      chk("R6 random irq", {31'd0, irq}, {31'd0, exp_irq(cm, fm)});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule